// File: doc/BRIEF.md
# Switchable Random Victim Selector

This block picks the way to evict when an 8-way set-associative cache misses. Two sources of randomness run side by side all the time. One is a 3-bit counter that steps on every clock. The other is a 16-bit maximal-length shift-register generator that also steps on every clock. A mode bit decides which source feeds the victim. Only a write flagged as privileged can change that mode bit or reseed the generator.

When the miss strobe is high, the selected source is captured into the victim register. The valid flag then rises for one cycle. The captured way stays on the output until the next miss, so the cache can use it over several cycles of a refill. Writes without privilege change nothing and produce a one-cycle error pulse.

The control port has two registers, chosen by one address bit. Address 0 holds the mode, taken from data bit 0: 0 selects the counter and 1 selects the generator. Address 1 holds the generator state, taken from all 16 data bits.

Top module: `victim_sel`

## Requirements
- R1: While reset is asserted and after it is released, the block is in a known state:
  - `victim_o` is 0, `victim_valid_o` is 0 and `cfg_err_o` is 0.
  - The mode is counter, the counter is 0 and the generator holds the seed (default 16'hACE1).
- R2: The counter advances by one, modulo 8, on every clock edge after reset, with or without a miss. In counter mode a miss captures the counter value present before that edge.
- R3: The generator advances on every clock edge that does not load it. The step is next = {s[14:0], s[15]^s[13]^s[12]^s[10]}, which is the polynomial x^16+x^14+x^13+x^11+1. In generator mode a miss captures the generator's low 3 bits present before that edge.
- R4: `victim_valid_o` is high in exactly the cycle after each cycle in which `miss_i` is high. `victim_o` does not change except on the edge that ends a miss cycle.
- R5: A privileged write to address 0 sets the mode from data bit 0 (1 selects the generator, 0 selects the counter). The new mode applies to misses from the next cycle on.
- R6: A privileged write to address 1 loads the generator with the written 16-bit value. It then steps from that value on the following edges.
- R7: A privileged write to address 1 with data 0 loads the seed instead, so the generator never holds zero.
- R8: A write with `cfg_priv_i` low changes neither the mode nor the generator. `cfg_err_o` is high for exactly the one cycle that follows it.
- R9: When a miss and a privileged write happen in the same cycle, the miss captures the mode and source values from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| miss_i | input | 1 | Miss strobe; captures a victim |
| cfg_we_i | input | 1 | Control register write enable |
| cfg_priv_i | input | 1 | Write carries privilege |
| cfg_addr_i | input | 1 | 0 = mode register, 1 = generator state |
| cfg_wdata_i | input | 16 | Write data |
| victim_o | output | 3 | Captured victim way |
| victim_valid_o | output | 1 | One-cycle pulse after a miss |
| cfg_err_o | output | 1 | One-cycle pulse after an unprivileged write |

## Verification
The bench targets these corner cases:
- A miss that arrives together with a mode write or a reseed. A design that applies the write first returns the wrong way.
- A reseed with zero. A design that does not substitute the seed locks the generator at 0, and every later victim becomes way 0.
- Unprivileged writes. If one leaks through, the victim sequence after it changes source or jumps.
- Misses spaced by idle cycles. A counter that steps only on misses shows its fault as consecutive ways where the free-running count would skip ahead.

// File: rtl/victim_sel.sv
module victim_sel #(
  parameter logic [15:0] SEED = 16'hACE1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        miss_i,
  input  logic        cfg_we_i,
  input  logic        cfg_priv_i,
  input  logic        cfg_addr_i,
  input  logic [15:0] cfg_wdata_i,
  output logic [2:0]  victim_o,
  output logic        victim_valid_o,
  output logic        cfg_err_o
);
  localparam int LW = 16;
  localparam int VW = 3;

  logic [VW-1:0] cnt_q;
  logic [LW-1:0] lfsr_q;
  logic          mode_q;

  logic wr_ok, wr_bad, fb;
  assign wr_ok  = cfg_we_i && cfg_priv_i;
  assign wr_bad = cfg_we_i && !cfg_priv_i;
  assign fb     = lfsr_q[15] ^ lfsr_q[13] ^ lfsr_q[12] ^ lfsr_q[10];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      lfsr_q <= SEED;
      mode_q <= 1'b0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
      if (wr_ok && !cfg_addr_i)
        mode_q <= cfg_wdata_i[0];
      if (wr_ok && cfg_addr_i)
        lfsr_q <= (cfg_wdata_i == '0) ? SEED : cfg_wdata_i;
      else
        lfsr_q <= {lfsr_q[LW-2:0], fb};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      victim_o       <= '0;
      victim_valid_o <= 1'b0;
      cfg_err_o      <= 1'b0;
    end else begin
      victim_valid_o <= miss_i;
      cfg_err_o      <= wr_bad;
      if (miss_i)
        victim_o <= mode_q ? lfsr_q[VW-1:0] : cnt_q;
    end
  end
endmodule

module victim_sel_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        miss_i,
  input logic        cfg_we_i,
  input logic        cfg_priv_i,
  input logic        cfg_addr_i,
  input logic [2:0]  victim_o,
  input logic        victim_valid_o,
  input logic        cfg_err_o,
  input logic        mode_q,
  input logic [15:0] lfsr_q,
  input logic [2:0]  cnt_q
);
  a_r2_free_count: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> cnt_q == 3'($past(cnt_q) + 3'd1));
  a_r3_shift: assert property (@(posedge clk) disable iff (!rst_n)
    !(cfg_we_i && cfg_priv_i && cfg_addr_i) |=> lfsr_q[15:1] == $past(lfsr_q[14:0]));
  a_r4_valid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    miss_i |=> victim_valid_o);
  a_r4_no_valid: assert property (@(posedge clk) disable iff (!rst_n)
    !miss_i |=> !victim_valid_o);
  a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !miss_i |=> $stable(victim_o));
  a_r7_never_zero: assert property (@(posedge clk) disable iff (!rst_n)
    lfsr_q != 16'h0000);
  a_r8_err_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we_i && !cfg_priv_i) |=> cfg_err_o);
  a_r8_no_err: assert property (@(posedge clk) disable iff (!rst_n)
    !(cfg_we_i && !cfg_priv_i) |=> !cfg_err_o);
  a_r8_mode_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we_i && !cfg_priv_i) |=> $stable(mode_q));
endmodule

bind victim_sel victim_sel_chk u_chk (
  .clk(clk), .rst_n(rst_n), .miss_i(miss_i), .cfg_we_i(cfg_we_i),
  .cfg_priv_i(cfg_priv_i), .cfg_addr_i(cfg_addr_i), .victim_o(victim_o),
  .victim_valid_o(victim_valid_o), .cfg_err_o(cfg_err_o),
  .mode_q(mode_q), .lfsr_q(lfsr_q), .cnt_q(cnt_q)
);

// File: tb/tb_victim_sel.sv
`timescale 1ns/1ps
module tb_victim_sel;
  localparam logic [15:0] SEED = 16'hACE1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic miss_i = 1'b0, cfg_we_i = 1'b0, cfg_priv_i = 1'b0, cfg_addr_i = 1'b0;
  logic [15:0] cfg_wdata_i = '0;
  logic [2:0] victim_o;
  logic victim_valid_o, cfg_err_o;

  always #10 clk = ~clk;

  victim_sel #(.SEED(SEED)) dut (
    .clk(clk), .rst_n(rst_n), .miss_i(miss_i), .cfg_we_i(cfg_we_i),
    .cfg_priv_i(cfg_priv_i), .cfg_addr_i(cfg_addr_i), .cfg_wdata_i(cfg_wdata_i),
    .victim_o(victim_o), .victim_valid_o(victim_valid_o), .cfg_err_o(cfg_err_o)
  );

  int checks = 0, fails = 0;
  bit done = 1'b0;

  logic [2:0]  m_cnt, m_vic;
  logic [15:0] m_lfsr;
  logic        m_mode, m_valid, m_err;

  // {miss, we, priv, addr, wdata}
  localparam int NV = 16;
  localparam logic [19:0] VEC [NV] = '{
    {4'b1000, 16'h0000}, {4'b0000, 16'h0000}, {4'b0000, 16'h0000},
    {4'b1000, 16'h0000}, {4'b1000, 16'h0000}, {4'b0100, 16'h0001},
    {4'b1000, 16'h0000}, {4'b0110, 16'h0001}, {4'b1000, 16'h0000},
    {4'b0000, 16'h0000}, {4'b1000, 16'h0000}, {4'b1101, 16'hFFFF},
    {4'b1000, 16'h0000}, {4'b0110, 16'h0000}, {4'b1000, 16'h0000},
    {4'b1000, 16'h0000}
  };

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic model_reset();
    m_cnt = '0; m_vic = '0; m_lfsr = SEED; m_mode = 1'b0; m_valid = 1'b0; m_err = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; miss_i = 0; cfg_we_i = 0; cfg_priv_i = 0; cfg_addr_i = 0; cfg_wdata_i = '0;
    model_reset();
    @(negedge clk);
    chk("R1", "victim in reset", victim_o, 0);
    chk("R1", "valid in reset", victim_valid_o, 0);
    chk("R1", "err in reset", cfg_err_o, 0);
    rst_n = 1'b1;
  endtask

  task automatic step(input logic mi, input logic we, input logic pv, input logic ad,
                      input logic [15:0] wd, input string tag);
    miss_i = mi; cfg_we_i = we; cfg_priv_i = pv; cfg_addr_i = ad; cfg_wdata_i = wd;
    @(posedge clk);
    if (mi) m_vic = m_mode ? m_lfsr[2:0] : m_cnt;
    m_valid = mi;
    m_err = we && !pv;
    if (we && pv && !ad) m_mode = wd[0];
    if (we && pv && ad) m_lfsr = (wd == 16'h0) ? SEED : wd;
    else m_lfsr = {m_lfsr[14:0], m_lfsr[15] ^ m_lfsr[13] ^ m_lfsr[12] ^ m_lfsr[10]};
    m_cnt = m_cnt + 3'd1;
    @(negedge clk);
    miss_i = 0; cfg_we_i = 0; cfg_priv_i = 0; cfg_addr_i = 0; cfg_wdata_i = '0;
    chk(tag, "victim", victim_o, m_vic);
    chk("R4", "valid", victim_valid_o, m_valid);
    chk("R8", "err", cfg_err_o, m_err);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    #(20ns * 5000);
    checks++; fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    do_reset();
    // Vector walk: counter mode, R2 gaps, R8 ignored write, mode switch, R3 runs
    for (int i = 0; i < NV; i++) begin
      logic [19:0] v;
      v = VEC[i];
      step(v[19], v[18], v[17], v[16], v[15:0], m_mode ? "R3" : "R2");
    end

    // R1: reset mid-run restores counter mode, count 0, seed
    do_reset();
    step(1, 0, 0, 0, 16'h0, "R1");
    chk("R1", "counter zero after reset", victim_o, 0);

    // R5: privileged mode write selects the generator
    step(0, 1, 1, 0, 16'h0001, "R5");
    step(1, 0, 0, 0, 16'h0, "R5");

    // R6: load known state then capture it
    step(0, 1, 1, 1, 16'h0005, "R6");
    step(1, 0, 0, 0, 16'h0, "R6");
    chk("R6", "loaded state low bits", victim_o, 5);

    // R7: zero load becomes seed
    step(0, 1, 1, 1, 16'h0000, "R7");
    step(1, 0, 0, 0, 16'h0, "R7");
    chk("R7", "seed low bits", victim_o, int'(SEED[2:0]));

    // R9: miss with reseed captures pre-write state, next miss sees the load
    step(1, 1, 1, 1, 16'h0003, "R9");
    step(1, 0, 0, 0, 16'h0, "R9");
    chk("R9", "value after same-cycle load", victim_o, 3);

    // R9: miss with mode write uses the old mode
    step(1, 1, 1, 0, 16'h0000, "R9");
    step(1, 0, 0, 0, 16'h0, "R2");

    // R8: unprivileged reseed and mode write leave the generator path unchanged
    step(0, 1, 1, 0, 16'h0001, "R5");
    step(0, 1, 0, 1, 16'h0007, "R8");
    step(0, 1, 0, 0, 16'h0000, "R8");
    step(1, 0, 0, 0, 16'h0, "R8");
    step(0, 0, 0, 0, 16'h0, "R4");
    step(0, 0, 0, 0, 16'h0, "R4");
    finish_run();
  end
endmodule